// File: doc/BRIEF.md
# 4-bit Character LCD Controller

This block drives a character display module that uses the common two-line controller with a 4-bit data path. After reset it runs the power-up reset sequence on its own: a long settle wait, three raw `0011` nibbles separated by graded waits, then five configuration bytes. After that it raises `req_ready` and accepts one byte at a time, tagged as command or data, over a valid/ready handshake.

Each byte goes to the panel as two nibble transfers, upper half first. Each transfer gets its own enable strobe with a guaranteed setup time, high time and hold time. Before every byte the controller turns the top data line around to an input and reads the panel's busy flag. A read is a pair of enable strobes, and the flag is sampled during the first strobe of the pair. The pair is repeated until the flag reads low. A bounded retry count turns a stuck panel into a sticky error instead of a hang. All waits count clock cycles, and the counts are derived from the `CLK_HZ` parameter.

States of the sequencer: `ST_PWR_WAIT` (settle wait) goes to `ST_RST_NIB` (raw nibble). That goes to `ST_RST_WAIT` (inter-nibble wait) and back to `ST_RST_NIB` until three nibbles are sent, then to `ST_POLL_A`. `ST_POLL_A` (first read strobe) goes to `ST_POLL_B` (second read strobe). `ST_POLL_B` returns to `ST_POLL_A` while busy, or goes to `ST_SEND_HI` when free or when retries run out. `ST_SEND_HI` goes to `ST_SEND_LO`. From `ST_SEND_LO` the sequencer goes to `ST_POST_WAIT` after the first configuration byte, to `ST_POLL_A` for the next configuration byte, or to `ST_IDLE`. `ST_POST_WAIT` goes to `ST_POLL_A`. `ST_IDLE` goes to `ST_POLL_A` when a request is accepted.

Top module: `lcd4_ctrl`

## Requirements
- R1: After reset release no enable pulse occurs for at least 15 ms of clock cycles. The first transfer is the nibble 0011 with `lcd_rs`=0 and `lcd_rw`=0, and no busy read comes before it.
- R2: The second and third 0011 nibbles follow after at least 4.1 ms and at least 100 µs, measured between rising enable edges. No busy read comes before either of them.
- R3: Configuration then sends the command bytes 0x20, 0x28, 0x0C, 0x06 and 0x01 in that order. There are at least 100 µs between the end of the 0x20 transfer and the next busy read.
- R4: A byte is sent as two write strobes on `lcd_db_o[3:0]` (bit 3 maps to the panel's DB7): first the upper nibble, then the lower nibble.
- R5: Command bytes go out with `lcd_rs`=0 and data bytes with `lcd_rs`=1. `lcd_rw` is 0 on every write strobe.
- R6: Before each byte the block issues read pairs with `lcd_rw`=1, `lcd_rs`=0 and `lcd_db_oe`=0111 (DB7 released). The flag is sampled in the first strobe of each pair, and pairs repeat while the sampled `lcd_db7_i` is 1. A byte whose first pair reads free is preceded by exactly two read strobes.
- R7: Between the last read strobe and the first write strobe there is at least one cycle in which `lcd_db_oe`=1111, `lcd_db_o[3]`=0 and `lcd_rw`=0.
- R8: `lcd_e` stays high for at least `T_EH` cycles. `lcd_rs`, `lcd_rw`, `lcd_db_o` and `lcd_db_oe` are steady for at least `T_SU` cycles before `lcd_e` rises and stay steady while it is high.
- R9: `req_ready` is 0 from reset until configuration is complete and for the whole time a byte is in flight. A byte is taken only in a cycle with `req_valid` and `req_ready` both 1. `req_valid` raised while `req_ready` is 0 produces no transfer.
- R10: If `MAX_POLLS` read pairs in a row all read busy, polling stops, `busy_err` becomes 1 and stays 1 until reset, and the byte is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte request present |
| req_rs | input | 1 | 1 = data byte, 0 = command byte |
| req_byte | input | 8 | Byte to send |
| req_ready | output | 1 | Controller can take a byte |
| lcd_rs | output | 1 | Register select pin |
| lcd_rw | output | 1 | Read/write pin (1 = read) |
| lcd_e | output | 1 | Enable strobe pin |
| lcd_db_o | output | 4 | Data nibble driven to DB7..DB4 (bit 3 = DB7) |
| lcd_db_oe | output | 4 | Per-line output enable for DB7..DB4 |
| lcd_db7_i | input | 1 | Busy flag read back from DB7 |
| busy_err | output | 1 | Sticky busy-poll timeout flag |

## Verification
A panel model holds the busy flag high for a chosen number of read pairs before each byte. Bytes are tried with zero, one and three busy pairs, and with a flag that never clears. These cases tell a correct retry loop apart from one that stops early, one that samples on the wrong strobe of the pair, and one that never times out. Command and data bytes with unlike upper and lower halves expose swapped nibble order and wrong select levels. A request held high while the block is busy shows whether the handshake gate leaks, and the spacing of the first enable edges shows whether each wait in the power-up sequence is long enough.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_RST_NIB,
        ST_RST_WAIT,
        ST_POLL_A,
        ST_POLL_B,
        ST_SEND_HI,
        ST_SEND_LO,
        ST_POST_WAIT,
        ST_IDLE
    } lcd_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } strobe_phase_e;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [3:0] nib;
        logic [3:0] oe;
    } bus_cmd_t;

    localparam int INIT_LEN = 5;

    // Configuration bytes, in the order they are issued.
    function automatic logic [7:0] init_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0:    b = 8'h20;
            3'd1:    b = 8'h28;
            3'd2:    b = 8'h0C;
            3'd3:    b = 8'h06;
            default: b = 8'h01;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd4_delay.sv
module lcd4_delay #(
    parameter int          W        = 16,
    parameter logic [W-1:0] RST_LOAD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_LOAD;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // Once expired, the timer stays expired until it is reloaded.
    a_r2_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/lcd4_strobe.sv
module lcd4_strobe
    import lcd4_pkg::*;
#(
    parameter int T_SU = 3,
    parameter int T_EH = 3,
    parameter int T_HD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bus_cmd_t   cmd,
    input  logic       db7_i,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [3:0] db_o,
    output logic [3:0] db_oe,
    output logic       done,
    output logic       rd_bit
);

    localparam int TMAX = (T_SU > T_EH) ? ((T_SU > T_HD) ? T_SU : T_HD)
                                        : ((T_EH > T_HD) ? T_EH : T_HD);
    localparam int TW   = $clog2(TMAX + 1);

    strobe_phase_e phase_q;
    logic [TW-1:0] cnt_q;
    bus_cmd_t      cur_q;
    logic          done_q;
    logic          rd_q;

    // Phase register and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
            done_q  <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                cur_q   <= cmd;
                phase_q <= PH_SETUP;
                cnt_q   <= TW'(T_SU - 1);
            end else begin
                unique case (phase_q)
                    PH_SETUP: begin
                        if (cnt_q == '0) begin
                            phase_q <= PH_HIGH;
                            cnt_q   <= TW'(T_EH - 1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (cnt_q == '0) begin
                            if (cur_q.rw) rd_q <= db7_i;
                            phase_q <= PH_HOLD;
                            cnt_q   <= TW'(T_HD - 1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_HOLD: begin
                        if (cnt_q == '0) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_IDLE: ;
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    // Pin outputs: parked (write, all lines driven low) when idle.
    always_comb begin
        if (phase_q == PH_IDLE) begin
            lcd_rs = 1'b0;
            lcd_rw = 1'b0;
            lcd_e  = 1'b0;
            db_o   = 4'h0;
            db_oe  = 4'hF;
        end else begin
            lcd_rs = cur_q.rs;
            lcd_rw = cur_q.rw;
            lcd_e  = (phase_q == PH_HIGH);
            db_o   = cur_q.nib & cur_q.oe;
            db_oe  = cur_q.oe;
        end
    end

    assign done   = done_q;
    assign rd_bit = rd_q;

    // Checker: width of the enable pulse.
    int unsigned e_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)     e_len_q <= 0;
        else if (lcd_e) e_len_q <= e_len_q + 1;
        else            e_len_q <= 0;
    end

    a_r8_e_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (e_len_q >= T_EH));

    a_r8_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> $stable({lcd_rs, lcd_rw, db_o, db_oe}));

endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl
    import lcd4_pkg::*;
#(
    parameter int CLK_HZ    = 4_194_000,
    parameter int T_SU      = 3,
    parameter int T_EH      = 3,
    parameter int T_HD      = 3,
    parameter int MAX_POLLS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_rs,
    input  logic [7:0] req_byte,
    output logic       req_ready,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [3:0] lcd_db_o,
    output logic [3:0] lcd_db_oe,
    input  logic       lcd_db7_i,
    output logic       busy_err
);

    localparam longint C15  = (longint'(CLK_HZ) * 15 + 999) / 1000;
    localparam longint C41  = (longint'(CLK_HZ) * 41 + 9999) / 10000;
    localparam longint C100 = (longint'(CLK_HZ) + 9999) / 10000;
    localparam int     DW   = $clog2(C15 + 1);
    localparam int     PW   = $clog2(MAX_POLLS + 1);

    lcd_state_e state_q, state_d;

    logic [1:0]    rst_cnt_q;
    logic [2:0]    init_idx_q;
    logic          init_mode_q;
    logic [7:0]    byte_q;
    logic          rs_q;
    logic          busy_q;
    logic [PW-1:0] poll_cnt_q;
    logic          err_q;

    logic          strobe_go, strobe_done, rd_bit;
    bus_cmd_t      cmd;
    logic          delay_load, delay_done;
    logic [DW-1:0] delay_val;

    logic [7:0]    cur_byte;
    logic          cur_rs;
    logic          entering;
    logic          last_init;
    logic          poll_again;

    assign cur_byte   = init_mode_q ? init_byte(init_idx_q) : byte_q;
    assign cur_rs     = init_mode_q ? 1'b0 : rs_q;
    assign entering   = (state_d != state_q);
    assign last_init  = (init_idx_q == 3'(INIT_LEN - 1));
    assign poll_again = busy_q && (poll_cnt_q != PW'(MAX_POLLS - 1));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWR_WAIT;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWR_WAIT:  if (delay_done) state_d = ST_RST_NIB;
            ST_RST_NIB:   if (strobe_done)
                              state_d = (rst_cnt_q == 2'd2) ? ST_POLL_A : ST_RST_WAIT;
            ST_RST_WAIT:  if (delay_done) state_d = ST_RST_NIB;
            ST_POLL_A:    if (strobe_done) state_d = ST_POLL_B;
            ST_POLL_B:    if (strobe_done)
                              state_d = poll_again ? ST_POLL_A : ST_SEND_HI;
            ST_SEND_HI:   if (strobe_done) state_d = ST_SEND_LO;
            ST_SEND_LO: begin
                if (strobe_done) begin
                    if (!init_mode_q)             state_d = ST_IDLE;
                    else if (init_idx_q == 3'd0)  state_d = ST_POST_WAIT;
                    else if (last_init)           state_d = ST_IDLE;
                    else                          state_d = ST_POLL_A;
                end
            end
            ST_POST_WAIT: if (delay_done) state_d = ST_POLL_A;
            ST_IDLE:      if (req_valid) state_d = ST_POLL_A;
            default:      state_d = ST_PWR_WAIT;
        endcase
    end

    // Sequencing context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt_q   <= '0;
            init_idx_q  <= '0;
            init_mode_q <= 1'b1;
            byte_q      <= '0;
            rs_q        <= 1'b0;
            busy_q      <= 1'b0;
            poll_cnt_q  <= '0;
            err_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RST_NIB: if (strobe_done) rst_cnt_q <= rst_cnt_q + 1'b1;
                ST_POLL_A:  if (strobe_done) busy_q <= rd_bit;
                ST_POLL_B: begin
                    if (strobe_done) begin
                        if (poll_again) begin
                            poll_cnt_q <= poll_cnt_q + 1'b1;
                        end else begin
                            poll_cnt_q <= '0;
                            if (busy_q) err_q <= 1'b1;
                        end
                    end
                end
                ST_SEND_LO: begin
                    if (strobe_done && init_mode_q) begin
                        if (last_init)               init_mode_q <= 1'b0;
                        else if (init_idx_q != 3'd0) init_idx_q  <= init_idx_q + 1'b1;
                    end
                end
                ST_POST_WAIT: if (delay_done) init_idx_q <= init_idx_q + 1'b1;
                ST_IDLE: begin
                    if (req_valid) begin
                        byte_q <= req_byte;
                        rs_q   <= req_rs;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs towards the strobe engine and the wait timer.
    always_comb begin
        cmd        = '{rs: 1'b0, rw: 1'b0, nib: 4'h0, oe: 4'hF};
        strobe_go  = 1'b0;
        delay_load = 1'b0;
        delay_val  = DW'(C100);
        unique case (state_d)
            ST_RST_NIB: begin
                strobe_go = entering;
                cmd.nib   = 4'b0011;
            end
            ST_POLL_A, ST_POLL_B: begin
                strobe_go = entering;
                cmd.rw    = 1'b1;
                cmd.oe    = 4'b0111;
            end
            ST_SEND_HI: begin
                strobe_go = entering;
                cmd.rs    = cur_rs;
                cmd.nib   = cur_byte[7:4];
            end
            ST_SEND_LO: begin
                strobe_go = entering;
                cmd.rs    = cur_rs;
                cmd.nib   = cur_byte[3:0];
            end
            ST_RST_WAIT: begin
                delay_load = entering;
                delay_val  = (rst_cnt_q == 2'd0) ? DW'(C41) : DW'(C100);
            end
            ST_POST_WAIT: begin
                delay_load = entering;
                delay_val  = DW'(C100);
            end
            default: ;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign busy_err  = err_q;

    lcd4_delay #(
        .W        (DW),
        .RST_LOAD (DW'(C15))
    ) i_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (delay_load),
        .load_val (delay_val),
        .done     (delay_done)
    );

    lcd4_strobe #(
        .T_SU (T_SU),
        .T_EH (T_EH),
        .T_HD (T_HD)
    ) i_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (strobe_go),
        .cmd    (cmd),
        .db7_i  (lcd_db7_i),
        .lcd_rs (lcd_rs),
        .lcd_rw (lcd_rw),
        .lcd_e  (lcd_e),
        .db_o   (lcd_db_o),
        .db_oe  (lcd_db_oe),
        .done   (strobe_done),
        .rd_bit (rd_bit)
    );

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!lcd_e && !lcd_rw));

    a_r9_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);

    a_r7_db7_restored: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_rw) |-> (lcd_db_oe == 4'hF && !lcd_db_o[3] && !lcd_e));

    a_r6_read_bus: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw |-> (lcd_db_oe == 4'b0111 && !lcd_rs));

    a_r5_write_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_HI || state_q == ST_SEND_LO || state_q == ST_RST_NIB) |-> !lcd_rw);

endmodule

// File: tb/test_lcd4_ctrl.sv
module test_lcd4_ctrl;

    localparam int CLK_HZ = 200_000;
    localparam int MAXP   = 8;
    localparam int TS     = 3;
    localparam int W15    = 3000;
    localparam int W41    = 820;
    localparam int W100   = 20;
    localparam int STUCK  = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_rs = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       req_ready;
    logic       lcd_rs, lcd_rw, lcd_e;
    logic [3:0] lcd_db_o, lcd_db_oe;
    logic       lcd_db7_i;
    logic       busy_err;

    always #10 clk = ~clk;

    lcd4_ctrl #(
        .CLK_HZ    (CLK_HZ),
        .T_SU      (TS),
        .T_EH      (TS),
        .T_HD      (TS),
        .MAX_POLLS (MAXP)
    ) i_lcd4_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_rs    (req_rs),
        .req_byte  (req_byte),
        .req_ready (req_ready),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_e     (lcd_e),
        .lcd_db_o  (lcd_db_o),
        .lcd_db_oe (lcd_db_oe),
        .lcd_db7_i (lcd_db7_i),
        .busy_err  (busy_err)
    );

    typedef struct {
        bit       rs;
        bit [3:0] nib;
        int       reads;
        bit       post;
    } exp_t;

    exp_t expq[$];
    int   errors = 0;
    int   checks = 0;

    // Panel model: busy for busy_left read pairs.
    int busy_left = 0;
    bit rd_phase  = 1'b0;
    assign lcd_db7_i = (busy_left > 0);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input string what, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
        end
    endtask

    task automatic push_byte(input bit rs, input logic [7:0] b, input int reads, input bit post);
        expq.push_back('{rs: rs, nib: b[7:4], reads: reads, post: 1'b0});
        expq.push_back('{rs: rs, nib: b[3:0], reads: 0, post: post});
    endtask

    // Monitor / scoreboard.
    int       cyc = 0;
    bit       prev_e = 1'b0;
    bit [9:0] prev_sig = '0;
    int       stab = 0;
    int       ehi = 0;
    bit       hi_changed = 1'b0;
    int       reads_since = 0;
    bit       saw_low = 1'b0;
    int       wr_rises = 0;
    int       last_rise = 0;
    int       post_fall = 0;
    bit       wait_post = 1'b0;
    bit       in_init = 1'b1;
    bit       ready_early = 1'b0;
    int       extra_writes = 0;

    always @(negedge clk) begin
        bit [9:0] sig;
        exp_t     e;
        sig = {lcd_rs, lcd_rw, lcd_db_o, lcd_db_oe};
        if (rst_n) begin
            cyc++;
            if (sig == prev_sig) stab++;
            else                 stab = 1;
            if (in_init && req_ready && expq.size() != 0) ready_early = 1'b1;

            if (lcd_e && !prev_e) begin
                chk_ge("R8", "setup cycles", stab - 1, TS);
                ehi = 1;
                hi_changed = 1'b0;
                if (lcd_rw) begin
                    chk("R6", "read bus oe", int'(lcd_db_oe), 7);
                    chk("R6", "read rs", int'(lcd_rs), 0);
                    if (wait_post) begin
                        chk_ge("R3", "gap after 0x20", cyc - post_fall, W100);
                        wait_post = 1'b0;
                    end
                end else begin
                    if (reads_since > 0) chk("R7", "db7 low before write", int'(saw_low), 1);
                    if (wr_rises == 0)      chk_ge("R1", "power-up wait", cyc, W15);
                    else if (wr_rises == 1) chk_ge("R2", "second nibble gap", cyc - last_rise, W41);
                    else if (wr_rises == 2) chk_ge("R2", "third nibble gap", cyc - last_rise, W100);
                    wr_rises++;
                    last_rise = cyc;
                end
            end else if (lcd_e && prev_e) begin
                ehi++;
                if (sig != prev_sig) hi_changed = 1'b1;
            end else if (!lcd_e && prev_e) begin
                chk_ge("R8", "E high cycles", ehi, TS);
                chk("R8", "bus steady while E high", int'(hi_changed), 0);
                if (lcd_rw) begin
                    reads_since++;
                    saw_low = 1'b0;
                    if (rd_phase && busy_left > 0 && busy_left < STUCK) busy_left--;
                    rd_phase = ~rd_phase;
                end else begin
                    if (expq.size() == 0) begin
                        extra_writes++;
                        errors++;
                        checks++;
                        $display("FAIL R9 unexpected write: actual=%0h expected=none", lcd_db_o);
                    end else begin
                        e = expq.pop_front();
                        chk("R5", "rs level", int'(lcd_rs), int'(e.rs));
                        chk("R4", "nibble", int'(lcd_db_o), int'(e.nib));
                        chk("R6", "reads before nibble", reads_since, e.reads);
                        if (e.post) begin
                            post_fall = cyc;
                            wait_post = 1'b1;
                        end
                    end
                    reads_since = 0;
                end
            end
            if (!lcd_e && !lcd_rw && lcd_db_oe == 4'hF && !lcd_db_o[3]) saw_low = 1'b1;
        end
        prev_e   = lcd_e;
        prev_sig = sig;
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && expq.size() == 0)) @(negedge clk);
    endtask

    task automatic send(input bit rs, input logic [7:0] b, input int busy, input int reads,
                        input bit poke);
        while (!req_ready) @(negedge clk);
        busy_left = busy;
        rd_phase  = 1'b0;
        push_byte(rs, b, reads, 1'b0);
        req_valid = 1'b1;
        req_rs    = rs;
        req_byte  = b;
        @(negedge clk);
        chk("R9", "ready after accept", int'(req_ready), 0);
        req_valid = 1'b0;
        if (poke) begin
            // R9: request while not ready must be ignored
            req_byte  = 8'hEE;
            req_valid = 1'b1;
            repeat (4) @(negedge clk);
            req_valid = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150_000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", wd);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9", "ready in reset", int'(req_ready), 0);
        chk("R1", "E in reset", int'(lcd_e), 0);
        chk("R1", "RW in reset", int'(lcd_rw), 0);
        chk("R10", "err in reset", int'(busy_err), 0);

        // Expected power-up traffic (R1, R2, R3).
        for (int k = 0; k < 3; k++) expq.push_back('{rs: 1'b0, nib: 4'h3, reads: 0, post: 1'b0});
        push_byte(1'b0, 8'h20, 6, 1'b1);
        push_byte(1'b0, 8'h28, 2, 1'b0);
        push_byte(1'b0, 8'h0C, 2, 1'b0);
        push_byte(1'b0, 8'h06, 2, 1'b0);
        push_byte(1'b0, 8'h01, 2, 1'b0);
        busy_left = 2;
        rst_n = 1'b1;

        while (!req_ready) @(negedge clk);
        in_init = 1'b0;
        chk("R9", "ready before init end", int'(ready_early), 0);
        chk("R3", "init bytes left", expq.size(), 0);

        send(1'b0, 8'h80, 0, 2, 1'b0);
        send(1'b1, 8'h41, 1, 4, 1'b1);
        chk("R9", "ignored request writes", extra_writes, 0);
        send(1'b1, 8'h5A, 3, 8, 1'b0);
        send(1'b0, 8'hC7, 0, 2, 1'b0);
        chk("R10", "err before timeout", int'(busy_err), 0);

        send(1'b1, 8'h3C, STUCK, 2 * MAXP, 1'b0);
        chk("R10", "err after timeout", int'(busy_err), 1);
        send(1'b0, 8'h0F, 0, 2, 1'b0);
        chk("R10", "err sticky", int'(busy_err), 1);

        repeat (20) @(negedge clk);
        chk("R4", "queue drained", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule